// File: doc/BRIEF.md
# Bit-Masked GPIO Port

This block is an eight-pin general-purpose I/O port on a simple single-cycle register bus. Each pin has a direction bit and an output data bit. The pad output value and the output enable come straight from these registers. The pad inputs reach the read path through a two-stage synchronizer.

Pin data is reached through a window of word addresses. The low address bits of a data access act as a per-pin select mask. Software can therefore set, clear or test any subset of pins in one bus cycle, with no read-modify-write. Unselected pins are left unchanged on a write and read back as zero.

The bus carries word addresses, so byte-offset bits are not present. A data access with word address `w` below 256 uses `w[7:0]` as its mask. This is byte offset `4*w` in the range 0x000 to 0x3FC. Word address 256 (byte offset 0x400) holds the direction register. Read data is registered and appears in the cycle after the read request.

Top module: `gpio_maskport`

## Requirements
- R1: After synchronous reset, `pad_oe` is 0x00 (all pins inputs), `pad_out` is 0x00, and `bus_rdata` is 0x00.
- R2: A write to word address 0x100 (byte offset 0x400) loads the direction register, which drives `pad_oe` from the next cycle. Bit n = 1 makes pin n an output. A read of that address returns the register.
- R3: A write to word address `w` < 0x100 sets output bit n to `bus_wdata[n]` for every n where mask bit `w[n]` is 1. The mask is byte-offset bit n+2.
- R4: A data write leaves every output bit whose mask bit is 0 unchanged.
- R5: A data read returns 0 in every bit whose mask bit is 0. A single-bit mask read is therefore nonzero exactly when that pin reads high.
- R6: In a data read, a selected pin whose direction bit is 1 returns its driven output value.
- R7: In a data read, a selected input pin returns the pad input through a two-flop synchronizer. A pad change made before rising edge k is first returned by a read sampled at edge k+2, and not by one sampled at edge k+1.
- R8: A data write to an input pin stores the value. When the pin is later switched to output, that value drives `pad_out`. Writing the same value again leaves the pin unchanged.
- R9: Word addresses above 0x100 read as 0x00, and writes to them change neither `pad_out` nor `pad_oe`.
- R10: `bus_rdata` carries the read result in the cycle after a read request and is 0x00 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte offset bits 11:2) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The following rules are checked on every cycle by assertions:
- Each data write touches only selected bits and loads them from the write data.
- A direction write lands on the output enables.
- Outputs never move without a write.
- Unselected and unmapped reads are zero.
- Output pins read back their driven value.

Some behaviour can only be shown by the bench's scenarios:
- The two-cycle synchronizer latency on input reads.
- The store-then-enable sequence for a pin written while it is an input.
- The mixed readback of a port split between inputs and outputs.

// File: rtl/gpio_maskport_pkg.sv
package gpio_maskport_pkg;

    localparam int GP_NPIN   = 8;
    localparam int GP_ADDR_W = 12;
    localparam int GP_SYNC   = 2;

    typedef enum logic [1:0] {
        RG_DATA = 2'd0,
        RG_DIR  = 2'd1,
        RG_NONE = 2'd2
    } gp_region_e;

    typedef struct packed {
        logic       req;
        logic       we;
        gp_region_e region;
    } gp_access_t;

endpackage

// File: rtl/gpio_mp_decode.sv
module gpio_mp_decode
    import gpio_maskport_pkg::*;
#(
    parameter int NPIN   = GP_NPIN,
    parameter int ADDR_W = GP_ADDR_W
) (
    input  logic [ADDR_W-1:2] addr,
    output gp_region_e        region,
    output logic [NPIN-1:0]   mask
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1) << NPIN;

    logic [WORD_W-1:0] word;
    logic              in_window;

    assign word      = addr;
    assign in_window = (word >> NPIN) == '0;

    always_comb begin
        if (in_window) begin
            region = RG_DATA;
        end else if (word == DIR_WORD) begin
            region = RG_DIR;
        end else begin
            region = RG_NONE;
        end
        mask = in_window ? word[NPIN-1:0] : '0;
    end

endmodule

// File: rtl/gpio_mp_sync.sv
module gpio_mp_sync
    import gpio_maskport_pkg::*;
#(
    parameter int NPIN   = GP_NPIN,
    parameter int STAGES = GP_SYNC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] din,
    output logic [NPIN-1:0] dout
);
    logic [NPIN-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= din;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '0;
                end else begin
                    stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_mp_regs.sv
module gpio_mp_regs
    import gpio_maskport_pkg::*;
#(
    parameter int NPIN = GP_NPIN
) (
    input  logic            clk,
    input  logic            rst,
    input  gp_access_t      acc,
    input  logic [NPIN-1:0] mask,
    input  logic [NPIN-1:0] wdata,
    input  logic [NPIN-1:0] pin_sync,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] dout_q,
    output logic [NPIN-1:0] rdata_q
);
    logic [NPIN-1:0] pin_view;
    logic [NPIN-1:0] rd_val;
    logic [NPIN-1:0] dout_next;
    logic            wr_data;
    logic            wr_dir;
    logic            rd_any;

    assign wr_data = acc.req && acc.we && (acc.region == RG_DATA);
    assign wr_dir  = acc.req && acc.we && (acc.region == RG_DIR);
    assign rd_any  = acc.req && !acc.we;

    generate
        for (genvar n = 0; n < NPIN; n++) begin : g_pin
            assign pin_view[n]  = dir_q[n] ? dout_q[n] : pin_sync[n];
            assign dout_next[n] = mask[n] ? wdata[n] : dout_q[n];
        end
    endgenerate

    always_comb begin
        case (acc.region)
            RG_DATA: rd_val = pin_view & mask;
            RG_DIR:  rd_val = dir_q;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            dout_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_data) begin
                dout_q <= dout_next;
            end
            if (wr_dir) begin
                dir_q <= wdata;
            end
            rdata_q <= rd_any ? rd_val : '0;
        end
    end

endmodule

// File: rtl/gpio_maskport.sv
module gpio_maskport
    import gpio_maskport_pkg::*;
#(
    parameter int NPIN   = GP_NPIN,
    parameter int ADDR_W = GP_ADDR_W,
    parameter int STAGES = GP_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:2] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe
);
    gp_region_e      region;
    logic [NPIN-1:0] mask;
    logic [NPIN-1:0] pin_sync;
    gp_access_t      acc;

    assign acc.req    = bus_req;
    assign acc.we     = bus_we;
    assign acc.region = region;

    gpio_mp_decode #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_decode (
        .addr   (bus_addr),
        .region (region),
        .mask   (mask)
    );

    gpio_mp_sync #(.NPIN(NPIN), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .dout (pin_sync)
    );

    gpio_mp_regs #(.NPIN(NPIN)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .mask     (mask),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .dir_q    (pad_oe),
        .dout_q   (pad_out),
        .rdata_q  (bus_rdata)
    );

endmodule

// File: rtl/gpio_maskport_chk.sv
module gpio_maskport_chk #(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:2] bus_addr,
    input logic [NPIN-1:0]   bus_wdata,
    input logic [NPIN-1:0]   bus_rdata,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   pad_oe
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] w;
    logic              win;
    logic              dir_hit;
    logic [NPIN-1:0]   sel;
    logic              rst_d;

    assign w       = bus_addr;
    assign win     = (w >> NPIN) == '0;
    assign dir_hit = w == (WORD_W'(1) << NPIN);
    assign sel     = w[NPIN-1:0];

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d && !rst) begin
            AST_RESET_STATE: assert (pad_oe == '0 && pad_out == '0 && bus_rdata == '0); // R1
        end
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && dir_hit |=> pad_oe == $past(bus_wdata)); // R2

    AST_MASKED_LOAD: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && win |=> (pad_out & $past(sel)) == ($past(bus_wdata) & $past(sel))); // R3

    AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && win |=> ((pad_out ^ $past(pad_out)) & ~$past(sel)) == '0); // R4

    AST_UNSEL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_we && win |=> (bus_rdata & ~$past(sel)) == '0); // R5

    AST_OUT_READBACK: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_we && win |=>
            (bus_rdata & $past(sel & pad_oe)) == $past(pad_out & sel & pad_oe)); // R6

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_we && !win && !dir_hit |=> bus_rdata == '0); // R9

    AST_UNMAPPED_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && !win && !dir_hit |=> $stable(pad_out) && $stable(pad_oe)); // R9

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && !bus_we) |=> bus_rdata == '0); // R10

endmodule

bind gpio_maskport gpio_maskport_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_maskport_bench.sv
`timescale 1ns/1ps
module gpio_maskport_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       bus_req;
    logic       bus_we;
    logic [9:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gpio_maskport u_gpio_maskport (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
    endtask

    task automatic t_direction();
        logic [7:0] r;
        wr(10'h100, 8'hA5);
        check("R2 pad_oe", pad_oe, 8'hA5);
        rd(10'h100, r);
        check("R2 readback", r, 8'hA5);
    endtask

    task automatic t_masked_write();
        wr(10'h100, 8'hFF);
        wr(10'h0FF, 8'h00);
        wr(10'h008, 8'hFF);
        check("R3 single pin", pad_out, 8'h08);
        wr(10'h081, 8'h7E);
        check("R4 others kept", pad_out, 8'h08);
        wr(10'h081, 8'hFF);
        check("R3 two pins", pad_out, 8'h89);
    endtask

    task automatic t_masked_read();
        logic [7:0] r;
        rd(10'h0FF, r);
        check("R6 full read", r, 8'h89);
        rd(10'h00F, r);
        check("R5 low nibble", r, 8'h09);
        rd(10'h002, r);
        check("R5 pin1 low", r, 8'h00);
        rd(10'h080, r);
        check("R5 pin7 high", r, 8'h80);
        @(negedge clk);
        check("R10 idle zero", bus_rdata, 8'h00);
    endtask

    task automatic t_input_sync();
        logic [7:0] r0, r1, r2;
        wr(10'h100, 8'h00);
        pad_in = 8'h00;
        repeat (4) @(negedge clk);
        pad_in = 8'hC3;
        rd(10'h0FF, r0);
        rd(10'h0FF, r1);
        rd(10'h0FF, r2);
        check("R7 edge k", r0, 8'h00);
        check("R7 edge k+1", r1, 8'h00);
        check("R7 edge k+2", r2, 8'hC3);
        wr(10'h100, 8'h0F);
        rd(10'h0FF, r0);
        check("R7 R6 mixed", r0, 8'hC9);
    endtask

    task automatic t_store_then_enable();
        logic [7:0] r;
        wr(10'h100, 8'h00);
        wr(10'h0FF, 8'h00);
        wr(10'h004, 8'h04);
        check("R8 oe still off", pad_oe, 8'h00);
        check("R8 stored", pad_out, 8'h04);
        wr(10'h100, 8'h04);
        wr(10'h004, 8'h04);
        check("R8 rewrite", pad_out, 8'h04);
        rd(10'h004, r);
        check("R8 readback", r, 8'h04);
    endtask

    task automatic t_unmapped();
        logic [7:0] r;
        wr(10'h101, 8'hFF);
        wr(10'h200, 8'hFF);
        check("R9 pad_out", pad_out, 8'h04);
        check("R9 pad_oe", pad_oe, 8'h04);
        rd(10'h101, r);
        check("R9 read 0x404", r, 8'h00);
        rd(10'h3FF, r);
        check("R9 read top", r, 8'h00);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_direction();
        t_masked_write();
        t_masked_read();
        t_input_sync();
        t_store_then_enable();
        t_unmapped();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule